// File: doc/BRIEF.md
# Priority-Stacked Interrupt Acceptance Unit

This unit sits beside a processor core and decides when an interrupt may be taken. It holds an 8-bit level history register made of four 2-bit slots. The lowest slot is the running level (0 to 3) and the upper three slots remember earlier levels. Taking an interrupt, or an explicit level-set command, pushes the history up by one slot and writes the new level into the lowest slot. A level-restore command (also used on interrupt return) rotates the register down by one slot, so the running level wraps around into the top slot.

There are five internal sources, always enabled and fixed at level 3. There are also `NUM_EXT` external sources, each with a level driven at the port. A request is taken only if its level is strictly above the running level, no entry is in progress, and the core is not between a chained-atomic instruction and the instruction after it. When more than one request qualifies, the unit picks one, returns a one-cycle acknowledge to that source, and runs a fixed 10-clock entry sequence. At the end of that sequence it presents the call target, formed from the internal or external table base byte and the source's slot index. When user mode is active, a move to level 3 is recorded as level 2.

Top module: `prio_irq_ctl`

## Requirements
- R1: After a synchronous reset the history register reads 8'h03 (running level 3). `busy`, `vec_valid` and all acknowledge outputs are low.
- R2: A level-set command (`set_req` with `set_lvl`) shifts the history left by two bits and loads the level into bits 1:0.
- R3: A restore command (`pop_req`) rotates the history right by two bits: the old bits 1:0 become bits 7:6 and the new running level is the old bits 3:2.
- R4: A request is accepted only when its level is strictly greater than the running level. A level-3 request is blocked at level 3, and an external source at level 0 is never accepted.
- R5: While `user_en` and `user_mode` are both high, any push of level 3, whether from entry or from a set command, stores level 2 instead.
- R6: Among eligible requests the highest level wins. On equal levels the lowest position wins. Internal sources hold positions 0 to 4 and external source k holds position 5+k, so internal sources beat external ones of the same level.
- R7: Internal request k always requests at level 3 and cannot be masked.
- R8: No request is accepted in a cycle where `atomic_hold` is high. The same request is accepted in the first cycle after it drops.
- R9: On the accepting clock edge the history is pushed with the winner's (capped) level. The winner's acknowledge bit is high for exactly the following cycle. `busy` is high for exactly 10 cycles, `vec_valid` is high only in the 10th of them, and no new acceptance occurs while `busy` is high.
- R10: The target address is {base, 8'h00} + 16 × k. `int_base` and source index k (0 to 4) are used for internal source k. `ext_base` and index k are used for external source k.
- R11: While `busy` is high, set and restore commands are ignored. In a cycle where a request is accepted, set and restore are also ignored. When set and restore arrive together, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req | input | 5 | Internal fixed-level-3 requests |
| ext_req | input | NUM_EXT | External requests |
| ext_lvl | input | 2*NUM_EXT | Level of each external source, source k in bits 2k+1:2k |
| user_en | input | 1 | User/system mode separation enabled |
| user_mode | input | 1 | Core currently in user mode |
| atomic_hold | input | 1 | Chained-atomic window, blocks acceptance |
| set_req | input | 1 | Level-set command |
| set_lvl | input | 2 | Level for the set command |
| pop_req | input | 1 | Level-restore or return command |
| int_base | input | 8 | Internal table base, upper address byte |
| ext_base | input | 8 | External table base, upper address byte |
| prio_stack | output | 8 | Level history register |
| cur_lvl | output | 2 | Running level (history bits 1:0) |
| busy | output | 1 | Entry sequence in progress |
| ack_int | output | 5 | Acknowledge pulse to internal sources |
| ack_ext | output | NUM_EXT | Acknowledge pulse to external sources |
| vec_valid | output | 1 | Target address is presented (last entry cycle) |
| vec_addr | output | 16 | Call target address |

## Verification
The hardest case to reach is a request that stays eligible through a whole entry sequence. It must be refused on every busy cycle and then taken again in the first idle cycle. At reset the running level is 3, so a level-3 source can never be taken from there. The stimulus therefore turns on user mode, so the entry records level 2, and holds an internal request high. This makes the unit re-enter exactly one cycle after `busy` falls, and the bench checks the 10-high, 1-low pattern. A second hard case is a command racing an acceptance. The bench raises set and restore in the same cycle as an accepted request, and again while the sequence is running, then reads back the history register to confirm that only the entry push landed.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int LVL_W     = 2;
    localparam int STK_W     = 8;
    localparam int STK_SLOTS = STK_W / LVL_W;
    localparam int INT_SRC   = 5;
    localparam int BASE_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int SLOT_LOG2 = 4;
    localparam int IDX_W     = 5;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [STK_W-1:0] stk_t;

    localparam lvl_t LVL_MAX        = 2'd3;
    localparam lvl_t LVL_USER_CEIL  = 2'd2;
    localparam stk_t STK_RESET      = 8'h03;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    typedef struct packed {
        stk_op_e op;
        lvl_t    lvl;
    } stk_cmd_t;

    typedef struct packed {
        logic             hit;
        logic             ext;
        logic [IDX_W-1:0] idx;
        lvl_t             lvl;
    } win_t;

    function automatic lvl_t cap_level(lvl_t want, logic user_on);
        return (user_on && want == LVL_MAX) ? LVL_USER_CEIL : want;
    endfunction

    function automatic logic [ADDR_W-1:0] slot_addr(logic [BASE_W-1:0] base,
                                                    logic [IDX_W-1:0] idx);
        logic [ADDR_W-1:0] off;
        off = {{(ADDR_W-IDX_W){1'b0}}, idx} << SLOT_LOG2;
        return {base, {(ADDR_W-BASE_W){1'b0}}} + off;
    endfunction

    function automatic stk_t stk_push(stk_t s, lvl_t l);
        return {s[STK_W-LVL_W-1:0], l};
    endfunction

    function automatic stk_t stk_rotate(stk_t s);
        return {s[LVL_W-1:0], s[STK_W-1:LVL_W]};
    endfunction

endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N     = 13,
    parameter int POS_W = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       req,
    input  logic [N*LVL_W-1:0] lvl_flat,
    input  lvl_t               cur_lvl,
    input  logic               allow,
    output logic               hit,
    output logic [POS_W-1:0]   pos,
    output lvl_t               win_lvl,
    output logic [N-1:0]       grant
);

    lvl_t       lvls [N];
    logic [N-1:0] elig;

    for (genvar g = 0; g < N; g++) begin : g_src
        assign lvls[g] = lvl_flat[g*LVL_W +: LVL_W];
        assign elig[g] = req[g] && (lvls[g] > cur_lvl);
    end

    logic found;

    always_comb begin
        found   = 1'b0;
        pos     = '0;
        win_lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || lvls[i] > win_lvl)) begin
                found   = 1'b1;
                pos     = POS_W'(i);
                win_lvl = lvls[i];
            end
        end
        hit   = found && allow;
        grant = '0;
        if (hit) grant[pos] = 1'b1;
    end

    a_r6_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r8_gate_closed: assert property (@(posedge clk) disable iff (rst)
        !allow |-> (grant == '0));

endmodule

// File: rtl/pic_prio_stack.sv
module pic_prio_stack
    import pic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  stk_cmd_t cmd,
    output stk_t     stack
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stack <= STK_RESET;
        end else begin
            case (cmd.op)
                STK_PUSH: stack <= stk_push(stack, cmd.lvl);
                STK_POP:  stack <= stk_rotate(stack);
                default:  stack <= stack;
            endcase
        end
    end

    a_r3_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == STK_POP) |=> ($countones(stack) == $countones($past(stack))));

    a_r2_history_moves_up: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == STK_PUSH) |=> (stack[STK_W-1:LVL_W] == $past(stack[STK_W-LVL_W-1:0])));

    a_r11_hold_is_stable: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == STK_HOLD) |=> $stable(stack));

endmodule

// File: rtl/pic_entry_seq.sv
module pic_entry_seq
    import pic_pkg::*;
#(
    parameter int ENTRY_CYCLES = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              busy,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr
);

    localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            vec_addr <= '0;
        end else if (start) begin
            cnt      <= CNT_W'(1);
            vec_addr <= addr_in;
        end else if (cnt == LAST) begin
            cnt      <= '0;
        end else if (cnt != '0) begin
            cnt      <= cnt + CNT_W'(1);
        end
    end

    assign busy      = (cnt != '0);
    assign vec_valid = (cnt == LAST);

    logic [CNT_W:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

    a_r9_valid_inside: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> busy);

    a_r9_release_after_valid: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !busy);

    a_r10_addr_held: assert property (@(posedge clk) disable iff (rst)
        (busy && !vec_valid) |=> $stable(vec_addr));

    a_r9_window_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == (CNT_W+1)'(ENTRY_CYCLES)));

endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
    import pic_pkg::*;
#(
    parameter int NUM_EXT      = 8,
    parameter int ENTRY_CYCLES = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [INT_SRC-1:0]     int_req,
    input  logic [NUM_EXT-1:0]     ext_req,
    input  logic [2*NUM_EXT-1:0]   ext_lvl,
    input  logic                   user_en,
    input  logic                   user_mode,
    input  logic                   atomic_hold,
    input  logic                   set_req,
    input  logic [1:0]             set_lvl,
    input  logic                   pop_req,
    input  logic [BASE_W-1:0]      int_base,
    input  logic [BASE_W-1:0]      ext_base,
    output logic [STK_W-1:0]       prio_stack,
    output logic [1:0]             cur_lvl,
    output logic                   busy,
    output logic [INT_SRC-1:0]     ack_int,
    output logic [NUM_EXT-1:0]     ack_ext,
    output logic                   vec_valid,
    output logic [ADDR_W-1:0]      vec_addr
);

    localparam int NSRC  = INT_SRC + NUM_EXT;
    localparam int POS_W = $clog2(NSRC);

    logic [NSRC-1:0]       req_all;
    logic [NSRC*LVL_W-1:0] lvl_all;

    assign req_all = {ext_req, int_req};

    for (genvar g = 0; g < INT_SRC; g++) begin : g_int_lvl
        assign lvl_all[g*LVL_W +: LVL_W] = LVL_MAX;
    end
    assign lvl_all[NSRC*LVL_W-1:INT_SRC*LVL_W] = ext_lvl;

    logic             allow;
    logic             hit;
    logic [POS_W-1:0] pos;
    lvl_t             win_lvl;
    logic [NSRC-1:0]  grant;

    assign allow = !busy && !atomic_hold;

    pic_arbiter #(.N(NSRC), .POS_W(POS_W)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .req      (req_all),
        .lvl_flat (lvl_all),
        .cur_lvl  (cur_lvl),
        .allow    (allow),
        .hit      (hit),
        .pos      (pos),
        .win_lvl  (win_lvl),
        .grant    (grant)
    );

    win_t              win;
    logic [ADDR_W-1:0] target;
    logic              user_on;

    assign user_on = user_en && user_mode;

    always_comb begin
        win.hit = hit;
        win.lvl = win_lvl;
        if (pos < POS_W'(INT_SRC)) begin
            win.ext = 1'b0;
            win.idx = IDX_W'(pos);
        end else begin
            win.ext = 1'b1;
            win.idx = IDX_W'(pos - POS_W'(INT_SRC));
        end
        target = win.ext ? slot_addr(ext_base, win.idx) : slot_addr(int_base, win.idx);
    end

    stk_cmd_t cmd;

    always_comb begin
        cmd.op  = STK_HOLD;
        cmd.lvl = '0;
        if (win.hit) begin
            cmd.op  = STK_PUSH;
            cmd.lvl = cap_level(win.lvl, user_on);
        end else if (!busy && set_req) begin
            cmd.op  = STK_PUSH;
            cmd.lvl = cap_level(set_lvl, user_on);
        end else if (!busy && pop_req) begin
            cmd.op  = STK_POP;
        end
    end

    pic_prio_stack u_stack (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .stack (prio_stack)
    );

    assign cur_lvl = prio_stack[LVL_W-1:0];

    pic_entry_seq #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (win.hit),
        .addr_in   (target),
        .busy      (busy),
        .vec_valid (vec_valid),
        .vec_addr  (vec_addr)
    );

    logic [NSRC-1:0] ack_q;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= '0;
        else     ack_q <= grant;
    end

    assign ack_int = ack_q[INT_SRC-1:0];
    assign ack_ext = ack_q[NSRC-1:INT_SRC];

    a_r4_strictly_above: assert property (@(posedge clk) disable iff (rst)
        hit |-> (win_lvl > cur_lvl));

    a_r5_user_ceiling: assert property (@(posedge clk) disable iff (rst)
        (user_on && cmd.op == STK_PUSH) |=> (cur_lvl != LVL_MAX));

    a_r8_atomic_blocks: assert property (@(posedge clk) disable iff (rst)
        atomic_hold |=> !$rose(busy));

    a_r9_ack_on_entry: assert property (@(posedge clk) disable iff (rst)
        (ack_q != '0) |-> ($rose(busy) && $countones(ack_q) == 1));

endmodule

// File: tb/prio_irq_ctl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  int_req;
    logic [7:0]  ext_req;
    logic [15:0] ext_lvl;
    logic        user_en, user_mode, atomic_hold;
    logic        set_req, pop_req;
    logic [1:0]  set_lvl;
    logic [7:0]  int_base, ext_base;
    logic [7:0]  prio_stack;
    logic [1:0]  cur_lvl;
    logic        busy, vec_valid;
    logic [4:0]  ack_int;
    logic [7:0]  ack_ext;
    logic [15:0] vec_addr;

    always #2 clk = ~clk;

    prio_irq_ctl u_dut (
        .clk(clk), .rst(rst), .int_req(int_req), .ext_req(ext_req), .ext_lvl(ext_lvl),
        .user_en(user_en), .user_mode(user_mode), .atomic_hold(atomic_hold),
        .set_req(set_req), .set_lvl(set_lvl), .pop_req(pop_req),
        .int_base(int_base), .ext_base(ext_base), .prio_stack(prio_stack),
        .cur_lvl(cur_lvl), .busy(busy), .ack_int(ack_int), .ack_ext(ack_ext),
        .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    int total = 0;
    int bad   = 0;
    logic finished = 1'b0;

    typedef struct packed {
        logic [1:0]  cur;
        logic [4:0]  ireq;
        logic [7:0]  ereq;
        logic [15:0] elvl;
        logic        usr;
        logic        acc;
        logic [15:0] addr;
        logic [1:0]  lvl;
    } vec_t;

    // bases: internal 8'hC4, external 8'h3A
    localparam vec_t VECS [12] = '{
        '{2'd0, 5'h00, 8'h04, 16'h0010, 1'b0, 1'b1, 16'h3A20, 2'd1}, // R10 ext2 lvl1
        '{2'd1, 5'h00, 8'h04, 16'h0010, 1'b0, 1'b0, 16'h0000, 2'd1}, // R4 equal level
        '{2'd3, 5'h01, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h0000, 2'd3}, // R4 level3 at 3
        '{2'd2, 5'h08, 8'h00, 16'h0000, 1'b0, 1'b1, 16'hC430, 2'd3}, // R7 internal3
        '{2'd2, 5'h08, 8'h00, 16'h0000, 1'b1, 1'b1, 16'hC430, 2'd2}, // R5 capped
        '{2'd0, 5'h00, 8'h22, 16'h0C08, 1'b0, 1'b1, 16'h3A50, 2'd3}, // R6 higher wins
        '{2'd0, 5'h00, 8'h48, 16'h2080, 1'b0, 1'b1, 16'h3A30, 2'd2}, // R6 tie low pos
        '{2'd0, 5'h10, 8'h01, 16'h0003, 1'b0, 1'b1, 16'hC440, 2'd3}, // R6 internal first
        '{2'd0, 5'h00, 8'h80, 16'h0000, 1'b0, 1'b0, 16'h0000, 2'd0}, // R4 level0 never
        '{2'd1, 5'h06, 8'h00, 16'h0000, 1'b0, 1'b1, 16'hC410, 2'd3}, // R6 int1 over int2
        '{2'd1, 5'h00, 8'h11, 16'h0201, 1'b0, 1'b1, 16'h3A40, 2'd2}, // R4 only ext4
        '{2'd0, 5'h00, 8'h08, 16'h00C0, 1'b1, 1'b1, 16'h3A30, 2'd2}  // R5 ext capped
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_inputs();
        int_req = '0; ext_req = '0; ext_lvl = '0;
        user_en = 1'b0; user_mode = 1'b0; atomic_hold = 1'b0;
        set_req = 1'b0; set_lvl = '0; pop_req = 1'b0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic set_level(input logic [1:0] l);
        set_req = 1'b1; set_lvl = l;
        tick();
        set_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 40 && busy; k++) tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R9 actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int_base = 8'hC4;
        ext_base = 8'h3A;
        do_reset();

        // R1 reset state
        chk("R1 stack", prio_stack, 8'h03);
        chk("R1 level", cur_lvl, 2'd3);
        chk("R1 busy", busy, 1'b0);
        chk("R1 ack", {ack_int, ack_ext}, 13'h0);
        chk("R1 vec_valid", vec_valid, 1'b0);

        // vector table
        foreach (VECS[i]) begin
            do_reset();
            set_level(VECS[i].cur);
            int_req = VECS[i].ireq; ext_req = VECS[i].ereq; ext_lvl = VECS[i].elvl;
            user_en = VECS[i].usr; user_mode = VECS[i].usr;
            tick();
            clear_inputs();
            chk("R4 accept", busy, VECS[i].acc);
            chk("R5 R6 level", cur_lvl, VECS[i].lvl);
            if (VECS[i].acc) begin
                repeat (9) tick();
                chk("R9 vec_valid", vec_valid, 1'b1);
                chk("R10 addr", vec_addr, VECS[i].addr);
                tick();
                chk("R9 busy end", busy, 1'b0);
            end
        end

        // R2 set pushes
        do_reset();
        set_level(2'd1);
        chk("R2 push1", prio_stack, 8'h0D);
        set_level(2'd2);
        chk("R2 push2", prio_stack, 8'h36);

        // R3 rotate
        pop_req = 1'b1; tick(); pop_req = 1'b0;
        chk("R3 rot1", prio_stack, 8'h8D);
        chk("R3 level", cur_lvl, 2'd1);
        pop_req = 1'b1; tick(); pop_req = 1'b0;
        chk("R3 rot2", prio_stack, 8'h63);

        // R5 set in user mode
        do_reset();
        user_en = 1'b1; user_mode = 1'b1;
        set_level(2'd3);
        chk("R5 set capped", prio_stack, 8'h0E);
        user_mode = 1'b0;
        set_level(2'd3);
        chk("R5 set uncapped", prio_stack, 8'h3B);

        // R11 set beats pop
        do_reset();
        set_req = 1'b1; set_lvl = 2'd1; pop_req = 1'b1;
        tick();
        clear_inputs();
        chk("R11 set over pop", prio_stack, 8'h0D);

        // R8 atomic inhibit
        do_reset();
        set_level(2'd0);
        ext_req = 8'h01; ext_lvl = 16'h0001; atomic_hold = 1'b1;
        tick();
        chk("R8 blocked busy", busy, 1'b0);
        chk("R8 blocked stack", prio_stack, 8'h0C);
        atomic_hold = 1'b0;
        tick();
        ext_req = '0;
        chk("R8 released", busy, 1'b1);
        chk("R9 push on entry", prio_stack, 8'h31);
        chk("R9 ack ext", ack_ext, 8'h01);

        // R11 commands ignored while busy
        set_req = 1'b1; set_lvl = 2'd2; pop_req = 1'b1;
        tick();
        clear_inputs();
        chk("R9 ack one cycle", ack_ext, 8'h00);
        wait_idle();
        chk("R11 busy ignore", prio_stack, 8'h31);

        // R11 accept wins over set
        do_reset();
        set_level(2'd0);
        ext_req = 8'h01; ext_lvl = 16'h0001; set_req = 1'b1; set_lvl = 2'd2;
        tick();
        clear_inputs();
        chk("R11 accept over set", prio_stack, 8'h31);
        wait_idle();

        // R9 held request: window length and re-entry
        do_reset();
        set_level(2'd0);
        user_en = 1'b1; user_mode = 1'b1; int_req = 5'h01;
        tick();
        chk("R9 entry", busy, 1'b1);
        chk("R9 ack int", ack_int, 5'h01);
        chk("R5 R7 capped level", cur_lvl, 2'd2);
        begin
            int n = 0;
            int vv_at = -1;
            logic [15:0] vv_addr = '0;
            while (busy && n < 30) begin
                if (vec_valid) begin vv_at = n; vv_addr = vec_addr; end
                n++;
                tick();
            end
            chk("R9 busy length", n, 10);
            chk("R9 valid in last", vv_at, 9);
            chk("R10 internal0 addr", vv_addr, 16'hC400);
        end
        chk("R9 idle gap", busy, 1'b0);
        tick();
        chk("R9 reentry", busy, 1'b1);
        chk("R9 second push", prio_stack, 8'hCA);
        clear_inputs();
        wait_idle();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule